// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address a memory core sees during a four-beat burst. When a new access begins, a load strobe captures the whole incoming address: the high part is held for the whole burst and the two low bits become the burst's start point. Each later cycle in which the active-low advance input is driven low moves the two low bits to the next beat of the burst, while the high part stays put.

Two beat orders are offered and chosen by a mode input. In linear order, each beat adds one to the low bits and wraps inside the same aligned group of four. In interleaved order, the low bits are the start value XOR a beat count that runs modulo four. The output is always the full current address. Deciding when an access starts, and moving data, belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is low and on the first cycle after it, addr_o is all zeros.
- R2: A cycle with load_i high at the rising edge makes addr_o equal to that cycle's addr_i from the next cycle on, in either mode, also in the middle of a burst.
- R3: The bits of addr_o above the two low bits change only at a load and then take the loaded addr_i bits; advancing never alters them.
- R4: With load_i low and adv_n_i high at a rising edge, addr_o keeps its value.
- R5: With ilv_mode_i low (linear), each edge with adv_n_i low and load_i low adds one modulo 4 to the two low bits of addr_o.
- R6: With ilv_mode_i high (interleaved), after n advances the two low bits equal start XOR (n mod 4): start 00 gives 00,01,10,11; 01 gives 01,00,11,10; 10 gives 10,11,00,01; 11 gives 11,10,01,00.
- R7: At an edge where load_i is high, adv_n_i has no effect: addr_o becomes addr_i exactly, with no step applied.
- R8: After the fourth advance the low bits return to the start value and the order repeats from beat one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | High: capture addr_i as the start of a burst |
| adv_n_i | input | 1 | Low: step to the next beat |
| ilv_mode_i | input | 1 | 1 interleaved order, 0 linear order; held static during a burst |
| addr_i | input | ADDR_W | Address presented at the start of an access |
| addr_o | output | ADDR_W | Current burst address for the memory core |

## Verification
The bench walks every start value in both orders, past the fourth beat, so that a design that carried into the upper bits instead of wrapping, or that used an add where the XOR order is needed, shows a wrong address. It holds the advance input high over several cycles to catch a counter that drifts, and drives a load and an advance together to catch a design that steps the freshly loaded start. A reload in the middle of a burst catches a beat counter that is not cleared, which would leave the new burst starting from a later beat.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] beat_o
);
    typedef struct packed {
        logic [CNT_W-1:0] beat;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.beat = '0;
        end else if (step_i) begin
            st_d.beat = st_q.beat + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat_o = st_q.beat;
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic [ADDR_W-1:0]       addr_i,
    output logic [ADDR_W-CNT_W-1:0] upper_o,
    output logic [CNT_W-1:0]        start_o
);
    localparam int UP_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [UP_W-1:0]  upper;
        logic [CNT_W-1:0] start;
    } base_state_t;

    base_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.upper = addr_i[ADDR_W-1:CNT_W];
            st_d.start = addr_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign upper_o = st_q.upper;
    assign start_o = st_q.start;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] start_i,
    input  logic [CNT_W-1:0] beat_i,
    input  burst_order_e     order_i,
    output logic [CNT_W-1:0] low_o
);
    logic [CNT_W-1:0] ilv_low;
    logic [CNT_W-1:0] lin_low;

    // Interleaved order: each bit of the start flips with the beat count bit.
    for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start_i[b] ^ beat_i[b];
    end

    // Linear order: modulo add, the carry out of the top bit is dropped.
    assign lin_low = start_i + beat_i;

    always_comb begin
        unique case (order_i)
            ORD_INTERLEAVE: low_o = ilv_low;
            default:        low_o = lin_low;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              ilv_mode_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int UP_W = ADDR_W - CNT_W;

    logic [UP_W-1:0]  upper;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] beat;
    logic [CNT_W-1:0] low;
    logic             step;
    burst_order_e     order;

    // A load takes priority; the advance strobe is ignored in that cycle.
    assign step  = !adv_n_i && !load_i;
    assign order = burst_order_e'(ilv_mode_i);

    burst_base_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start)
    );

    burst_beat_ctr #(.CNT_W(CNT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_i),
        .step_i  (step),
        .beat_o  (beat)
    );

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .start_i (start),
        .beat_i  (beat),
        .order_i (order),
        .low_o   (low)
    );

    assign addr_o = {upper, low};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_n_i,
    input logic              ilv_mode_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o
);
    logic [CNT_W-1:0] lo;
    assign lo = addr_o[CNT_W-1:0];

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> addr_o == $past(addr_i)); // R7

    AST_UPPER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> addr_o[ADDR_W-1:CNT_W] == $past(addr_o[ADDR_W-1:CNT_W])); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) ##1 (ilv_mode_i == $past(ilv_mode_i)) |-> addr_o == $past(addr_o)); // R4

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !ilv_mode_i) ##1 !ilv_mode_i |-> lo == CNT_W'($past(lo) + 1'b1)); // R5
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
    localparam int ADDR_W = 20;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              load_i;
    logic              adv_n_i;
    logic              ilv_mode_i;
    logic [ADDR_W-1:0] addr_i;
    logic [ADDR_W-1:0] addr_o;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .CNT_W(2)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .adv_n_i(adv_n_i),
        .ilv_mode_i(ilv_mode_i), .addr_i(addr_i), .addr_o(addr_o)
    );

    // Vector: {mode, start[1:0], advances[2:0], expected low[1:0]}
    localparam logic [7:0] VEC [NVEC] = '{
        {1'b0, 2'd0, 3'd3, 2'd3},
        {1'b0, 2'd1, 3'd3, 2'd0},
        {1'b0, 2'd2, 3'd5, 2'd3},
        {1'b0, 2'd3, 3'd2, 2'd1},
        {1'b1, 2'd0, 3'd3, 2'd3},
        {1'b1, 2'd1, 3'd2, 2'd3},
        {1'b1, 2'd2, 3'd5, 2'd3},
        {1'b1, 2'd3, 3'd3, 2'd0},
        {1'b1, 2'd1, 3'd4, 2'd1},
        {1'b0, 2'd2, 3'd4, 2'd2}
    };

    task automatic chk(input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: addr_o=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven at a falling edge; return at the next falling edge.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic mode, input logic [ADDR_W-1:0] a, input logic adv_n);
        ilv_mode_i = mode; addr_i = a; load_i = 1'b1; adv_n_i = adv_n;
        tick();
        load_i = 1'b0; adv_n_i = 1'b1; addr_i = '0;
    endtask

    task automatic advance();
        adv_n_i = 1'b0;
        tick();
        adv_n_i = 1'b1;
    endtask

    function automatic logic [1:0] exp_low(input logic mode, input logic [1:0] s, input int n);
        logic [1:0] k;
        k = 2'(n % 4);
        return mode ? (s ^ k) : 2'(s + k);
    endfunction

    initial begin
        #3_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: addr_o=%h expected=finish", addr_o);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] base;
        rst_n = 1'b0; load_i = 1'b0; adv_n_i = 1'b1; ilv_mode_i = 1'b0; addr_i = '0;
        @(negedge clk);
        addr_i = 20'hABCDE; load_i = 1'b1; adv_n_i = 1'b0;
        tick();
        chk("R1 during reset", addr_o, '0);
        load_i = 1'b0; adv_n_i = 1'b1; addr_i = '0;
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", addr_o, '0);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            logic       m;
            logic [1:0] s;
            int         n;
            m = VEC[v][7]; s = VEC[v][6:5]; n = int'(VEC[v][4:2]);
            base = {18'(v * 20'h1357 + 18'h2A5), s};
            do_load(m, base, 1'b1);
            chk("R2 load", addr_o, base);
            for (int i = 0; i < n; i++) advance();
            chk(m ? "R6/R8 table interleaved" : "R5/R8 table linear",
                addr_o, {base[ADDR_W-1:2], VEC[v][1:0]});
        end

        // Beat-by-beat for every start in both modes, eight beats (wraps twice)
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                base = {18'h3F0F0 + 18'(s), 2'(s)};
                do_load(1'(m), base, 1'b1);
                for (int i = 1; i <= 8; i++) begin
                    advance();
                    if (m == 1) chk("R6 interleaved beat", addr_o, {base[ADDR_W-1:2], exp_low(1'b1, 2'(s), i)});
                    else        chk("R5 linear beat", addr_o, {base[ADDR_W-1:2], exp_low(1'b0, 2'(s), i)});
                    if (i == 4) chk("R8 back to start", addr_o, base);
                end
                chk("R3 upper held", {addr_o[ADDR_W-1:2], 2'b00}, {base[ADDR_W-1:2], 2'b00});
            end
        end

        // Advance held off
        base = 20'h12345;
        do_load(1'b1, base, 1'b1);
        advance();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 hold", addr_o, {base[ADDR_W-1:2], 2'b00});
        end

        // Load and advance together: no step
        base = 20'hFFFFE;
        do_load(1'b0, base, 1'b0);
        chk("R7 load with advance", addr_o, base);
        advance();
        chk("R7 first step after load", addr_o, 20'hFFFFF);
        advance();
        chk("R5 wrap no carry into upper", addr_o, 20'hFFFFC);

        // Reload mid-burst clears the beat count
        advance();
        base = 20'h0A0A3;
        do_load(1'b1, base, 1'b1);
        chk("R2 reload mid-burst", addr_o, base);
        advance();
        chk("R6 first beat after reload", addr_o, 20'h0A0A2);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule